// File: doc/BRIEF.md
# Multiplexed-Bus Register Slave with Sticky Detect Interrupt

This block is a small register file that sits behind an 8-bit processor bus on which address and data share the same lines. The processor puts a register number on the bus and marks it with an address-latch strobe. When that strobe falls, the block takes the register number and the chip-select level. A read strobe then has the block drive the bus with the selected register. A write strobe commits bus data into the selected register. All bus strobes are sampled on the block's system clock.

The block holds two control registers and a tone register, and all three clear on an active-high reset. It also keeps a read-only detect register. Detect events arrive as input pulses, are synchronized, and set sticky flags. Any pending flag pulls the open-drain, active-low interrupt. The interrupt stays asserted until the processor completes a read of the detect register. One control bit picks the source of a clock output. The faster baud-rate clock is used only while the differential phase-shift-keying mode bit is also set.

Top module: `mux_bus_regs`

## Requirements
- R1: On a falling edge of `ale`, the block captures `ad_in[2:0]` as the register address. That address is used by every read and write until the next falling edge.
- R2: `cs_n` is sampled on the same falling edge of `ale` and held. A later change of `cs_n` before the next falling edge has no effect on reads or writes.
- R3: If the held chip select is high, the bus output enable stays low and a write strobe changes no register.
- R4: `ad_oe` is high only while `rd_n` is low and the held chip select is low. While it is high, `ad_out` carries the addressed register.
- R5: The register map is: address 0 is control register A, address 1 is control register B, address 2 is the detect register, and address 3 is the tone register. The detect register is read-only and writes to it are ignored. Addresses 4 to 7 read as 0x00 and writes to them change nothing. A write commits `ad_in` on the rising edge of `wr_n`.
- R6: A rising edge on `det_evt[i]` sets detect flag i, which reads back as bit i of address 2. While any flag is set, `irq_pull` is 1 and `irq_pad` is 0. Otherwise `irq_pull` is 0 and `irq_pad` is high impedance.
- R7: Flags stay set, and the interrupt stays asserted, until a read of address 2 completes on the rising edge of `rd_n`. That read clears only the flags that were set when `rd_n` fell. An event that arrives during the read stays pending.
- R8: While `rst` is high, the two control registers, the tone register and the detect flags are all cleared, and `clk_out` follows `xtal_clk`.
- R9: `clk_out` follows `baud16_clk` only when control register B bit 7 (clock select) and control register A bit 0 (phase-shift-keying mode) are both 1. Otherwise it follows `xtal_clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all strobes are sampled on its rising edge |
| rst | input | 1 | Active-high reset |
| ale | input | 1 | Address-latch strobe; falling edge captures address and chip select |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| ad_in | input | 8 | Bus value seen by the block |
| ad_out | output | 8 | Read data driven onto the bus |
| ad_oe | output | 1 | Bus drive enable |
| det_evt | input | 8 | Asynchronous detect event pulses |
| irq_pull | output | 1 | Open-drain pull-down enable for the interrupt |
| irq_pad | output | 1 | Interrupt pad value: 0 or high impedance |
| xtal_clk | input | 1 | Crystal-rate clock |
| baud16_clk | input | 1 | Clock at 16 times the data rate |
| clk_out | output | 1 | Selected clock output |

## Verification
The hardest case to reach from the ports is an event that arrives after a detect-register read has started but before it ends. That event must survive the clear while the earlier flags are dropped. The bench first sets one flag and lowers `rd_n` with address 2 latched. It then pulses a different event input and holds `rd_n` low long enough for the synchronizer to deliver that event. Only then does it raise `rd_n`, and it reads the register again to confirm that only the late flag remains and the interrupt is still pulled.

// File: rtl/mux_bus_regs.sv
module mux_bus_regs #(
  parameter int DW   = 8,
  parameter int AW   = 3,
  parameter int NDET = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ale,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [DW-1:0] ad_in,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  input  logic [NDET-1:0] det_evt,
  output logic          irq_pull,
  output logic          irq_pad,
  input  logic          xtal_clk,
  input  logic          baud16_clk,
  output logic          clk_out
);
  localparam logic [AW-1:0] A_CRA  = AW'(0);
  localparam logic [AW-1:0] A_CRB  = AW'(1);
  localparam logic [AW-1:0] A_DET  = AW'(2);
  localparam logic [AW-1:0] A_TONE = AW'(3);

  logic          ale_q, rd_q, wr_q, sel_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] cra, crb, tone;
  logic [NDET-1:0] s1, s2, s3, flags, snap;

  wire ale_fall = ale_q & ~ale;
  wire rd_fall  = rd_q & ~rd_n;
  wire rd_rise  = ~rd_q & rd_n;
  wire wr_rise  = ~wr_q & wr_n;
  wire det_sel  = ~sel_n && addr == A_DET;
  wire det_done = det_sel & rd_rise;
  wire [NDET-1:0] evt_new = s2 & ~s3;

  always_ff @(posedge clk) begin
    if (rst) begin
      ale_q <= 1'b0; rd_q <= 1'b1; wr_q <= 1'b1;
      sel_n <= 1'b1; addr <= '0;
      cra <= '0; crb <= '0; tone <= '0;
      s1 <= '0; s2 <= '0; s3 <= '0;
      flags <= '0; snap <= '0;
    end else begin
      ale_q <= ale; rd_q <= rd_n; wr_q <= wr_n;
      s1 <= det_evt; s2 <= s1; s3 <= s2;
      if (ale_fall) begin
        addr  <= ad_in[AW-1:0];
        sel_n <= cs_n;
      end
      if (wr_rise && !sel_n) begin
        case (addr)
          A_CRA:   cra  <= ad_in;
          A_CRB:   crb  <= ad_in;
          A_TONE:  tone <= ad_in;
          default: ;
        endcase
      end
      if (det_sel && rd_fall) snap <= flags;
      if (det_done) flags <= (flags & ~snap) | evt_new;
      else          flags <= flags | evt_new;
    end
  end

  always_comb begin
    ad_out = '0;
    case (addr)
      A_CRA:   ad_out = cra;
      A_CRB:   ad_out = crb;
      A_DET:   ad_out = DW'(flags);
      A_TONE:  ad_out = tone;
      default: ad_out = '0;
    endcase
  end

  assign ad_oe    = ~rd_n & ~sel_n;
  assign irq_pull = |flags;
  assign irq_pad  = irq_pull ? 1'b0 : 1'bz;
  assign clk_out  = (crb[DW-1] & cra[0]) ? baud16_clk : xtal_clk;

  p_addr_latch_r1: assert property (@(posedge clk) disable iff (rst)
    ale_fall |=> addr == $past(ad_in[AW-1:0]));
  p_cs_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !ale_fall |=> $stable(sel_n));
  p_no_write_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_rise && sel_n) |=> ($stable(cra) && $stable(crb) && $stable(tone)));
  p_drive_rd_r4: assert property (@(posedge clk) disable iff (rst)
    ad_oe |-> !rd_n);
  p_irq_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (irq_pull && !det_done) |=> irq_pull);
  p_reset_clear_r8: assert property (@(posedge clk)
    rst |=> (cra == '0 && crb == '0 && tone == '0 && flags == '0));
endmodule

// File: tb/mux_bus_regs_test.sv
module mux_bus_regs_test;
  logic clk = 1'b0, rst = 1'b1, ale = 1'b0, cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] ad_in = '0, det_evt = '0;
  logic xtal_clk = 1'b1, baud16_clk = 1'b0;
  logic [7:0] ad_out;
  logic ad_oe, irq_pull, irq_pad, clk_out;
  int tests = 0, fails = 0;
  logic [7:0] rdat;
  logic roe;

  always #2 clk = ~clk;

  mux_bus_regs uut (.clk, .rst, .ale, .cs_n, .rd_n, .wr_n, .ad_in, .ad_out, .ad_oe,
    .det_evt, .irq_pull, .irq_pad, .xtal_clk, .baud16_clk, .clk_out);

  // {write addr, write data, read addr, expected}
  localparam logic [31:0] VEC [8] = '{
    {8'd0, 8'hA5, 8'd0, 8'hA5}, {8'd1, 8'h3C, 8'd1, 8'h3C},
    {8'd3, 8'h7E, 8'd3, 8'h7E}, {8'd2, 8'hFF, 8'd2, 8'h00},
    {8'd5, 8'h55, 8'd5, 8'h00}, {8'd7, 8'hAA, 8'd7, 8'h00},
    {8'd4, 8'h11, 8'd0, 8'hA5}, {8'd0, 8'h5A, 8'd0, 8'h5A}};

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic latch(input logic [7:0] a, input logic cs);
    @(negedge clk); ale = 1'b1; ad_in = a; cs_n = cs;
    @(negedge clk); ale = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_write(input logic [7:0] d);
    ad_in = d; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_read();
    rd_n = 1'b0; #1; rdat = ad_out; roe = ad_oe;
    @(negedge clk); rd_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse(input int bit_i);
    @(negedge clk); det_evt[bit_i] = 1'b1;
    @(negedge clk); det_evt[bit_i] = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #400000;
    fails++; tests++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // reset state (R8)
    check("R8 oe", {7'd0, ad_oe}, 8'd0);
    check("R8 irq", {7'd0, irq_pull}, 8'd0);
    check("R8 clk", {7'd0, clk_out}, {7'd0, xtal_clk});
    latch(8'd1, 1'b0); do_read(); check("R8 crb", rdat, 8'h00);
    latch(8'd3, 1'b0); do_read(); check("R8 tone", rdat, 8'h00);

    // vector walk (R1 R4 R5)
    for (int i = 0; i < 8; i++) begin
      latch(VEC[i][31:24], 1'b0); do_write(VEC[i][23:16]);
      latch(VEC[i][15:8], 1'b0); do_read();
      check("R5 map", rdat, VEC[i][7:0]);
      check("R4 oe", {7'd0, roe}, 8'd1);
    end
    // address bits above 2 ignored (R1)
    latch(8'hF9, 1'b0); do_read(); check("R1 low bits", rdat, 8'h3C);

    // cs sampled at latch (R2, R3)
    latch(8'd3, 1'b0); cs_n = 1'b1; do_read();
    check("R2 cs held low", {7'd0, roe}, 8'd1);
    check("R2 data", rdat, 8'h7E);
    latch(8'd3, 1'b1); cs_n = 1'b0; do_write(8'h00); do_read();
    check("R3 no drive", {7'd0, roe}, 8'd0);
    latch(8'd3, 1'b0); do_read(); check("R3 no write", rdat, 8'h7E);

    // detect and interrupt (R6 R7)
    pulse(3);
    check("R6 irq", {7'd0, irq_pull}, 8'd1);
    check("R6 pad", {7'd0, irq_pad}, 8'd0);
    repeat (20) @(negedge clk);
    latch(8'd0, 1'b0); do_read();
    check("R7 hold", {7'd0, irq_pull}, 8'd1);
    latch(8'd2, 1'b0); do_read();
    check("R6 flag", rdat, 8'h08);
    check("R7 cleared", {7'd0, irq_pull}, 8'd0);
    // event during the read stays pending (R7)
    pulse(0);
    latch(8'd2, 1'b0);
    rd_n = 1'b0;
    @(negedge clk); det_evt[1] = 1'b1;
    @(negedge clk); det_evt[1] = 1'b0;
    repeat (4) @(negedge clk);
    rd_n = 1'b1;
    @(negedge clk);
    check("R7 late irq", {7'd0, irq_pull}, 8'd1);
    do_read(); check("R7 late flag", rdat, 8'h02);
    check("R7 empty", {7'd0, irq_pull}, 8'd0);

    // clock select (R9)
    latch(8'd1, 1'b0); do_write(8'h80);
    latch(8'd0, 1'b0); do_write(8'h00);
    check("R9 no dpsk", {7'd0, clk_out}, {7'd0, xtal_clk});
    do_write(8'h01);
    check("R9 baud", {7'd0, clk_out}, {7'd0, baud16_clk});
    baud16_clk = 1'b1; xtal_clk = 1'b0; #1;
    check("R9 follow", {7'd0, clk_out}, 8'd1);

    // reset mid-run (R8)
    pulse(5);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); #1;
    check("R8 clk xtal", {7'd0, clk_out}, {7'd0, xtal_clk});
    check("R8 flags", {7'd0, irq_pull}, 8'd0);
    @(negedge clk); rst = 1'b0;
    latch(8'd0, 1'b0); do_read(); check("R8 cra", rdat, 8'h00);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule